// File: doc/BRIEF.md
# Frequency Multiplier Step Sequencer

This block sits between the clock configuration written by software and an internal frequency multiplier. Software supplies an enable, a reference-source choice and a 3-bit multiplier code. The multiplication factor is the code plus one, so the eight codes give factors one to eight. For example, a 4 MHz reference gives 8 MHz at code 1 and 16 MHz at code 3. When the multiplier is off, the block bypasses it and hands the selected oscillator straight to the system clock. When software turns the multiplier on, the block drives the multiplier's enable, waits for the lock input and then raises `ready`.

Once `ready` is high, the multiplier already clocks the system, so the block never jumps the code. It walks the applied code toward the requested target one stage per step and holds a settling delay of `SETTLE` cycles after each step. `ready` stays high for the whole walk. A separate `busy` output therefore tells software when the frequency has settled. If software writes a new target during a walk, the walk turns toward it without cutting short the delay already running. Dropping the enable aborts everything at once.

Top module: `pll_step_seq`

## Requirements
- R1: After reset, `ready` is 0, `busy` is 0 and `pll_code` is 0.
- R2: `pll_en` follows `cfg_enable` combinationally. While `ready` is 0, `pll_code` takes the value of `cfg_target` at every clock edge.
- R3: While `ready` is high, every change of `pll_code` is an increment or a decrement by exactly one, toward `cfg_target`.
- R4: While `ready` is high, the first step occurs at the first clock edge at which `pll_code` differs from `cfg_target` and no settling delay is running. Consecutive steps are exactly `SETTLE`+1 clock edges apart. `SETTLE` defaults to 10 and must be at least 1.
- R5: Once high, `ready` stays high for as long as `cfg_enable` stays high, whatever `pll_lock` and the walk do.
- R6: `ready` rises only at a clock edge at which `cfg_enable` and `pll_lock` are both high.
- R7: `ref_clk` equals `osc_xtal` when `cfg_src_sel` is 1, and `osc_rc` when `cfg_src_sel` is 0.
- R8: `sys_clk` equals `pll_clk` while `ready` is high and `ref_clk` otherwise, so a disabled multiplier is bypassed.
- R9: While `ready` is high, `busy` is high as soon as `cfg_target` differs from `pll_code`. It stays high until exactly `SETTLE` clock edges after the final step.
- R10: A target change during a walk does not shorten the running delay. The next step heads toward the newest target.
- R11: At the first clock edge with `cfg_enable` low, `ready` and `busy` clear, any walk stops, and `pll_code` takes `cfg_target`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Turns the multiplier on |
| cfg_src_sel | input | 1 | Reference choice: 0 internal RC, 1 crystal |
| cfg_target | input | CODE_W | Requested multiplier code (factor = code + 1) |
| osc_rc | input | 1 | Internal RC oscillator |
| osc_xtal | input | 1 | Crystal oscillator |
| pll_clk | input | 1 | Multiplier output clock |
| pll_lock | input | 1 | Lock indication from the multiplier |
| pll_en | output | 1 | Multiplier enable |
| pll_code | output | CODE_W | Code applied to the multiplier |
| ref_clk | output | 1 | Selected reference to the multiplier |
| sys_clk | output | 1 | System clock: multiplier output or bypassed reference |
| ready | output | 1 | Multiplier locked and in use |
| busy | output | 1 | A walk or its final settling delay is in progress |

## Verification
The bench walks from every start code to every target code with a short delay. It predicts the applied code and `busy` cycle by cycle, so it catches any design that skips a stage, steps one edge early or late, or clears `busy` at the last step instead of after its delay. One walk reverses mid-delay; a design that restarts or drops the delay would step too early. Another test aborts a walk by dropping the enable, which exposes a design that keeps a stale code or leaves `ready` high. Further tests hold lock low before enabling and drop it during a walk, which catch a `ready` that rises without lock or one that follows lock instead of staying sticky.

// File: rtl/pll_step_seq.sv
module pll_step_seq #(
  parameter int CODE_W = 3,
  parameter int SETTLE = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_src_sel,
  input  logic [CODE_W-1:0] cfg_target,
  input  logic              osc_rc,
  input  logic              osc_xtal,
  input  logic              pll_clk,
  input  logic              pll_lock,
  output logic              pll_en,
  output logic [CODE_W-1:0] pll_code,
  output logic              ref_clk,
  output logic              sys_clk,
  output logic              ready,
  output logic              busy
);
  localparam int CNT_W = $clog2(SETTLE + 1);

  logic [CNT_W-1:0] settle_cnt;
  logic             differs, step_up;

  assign differs = pll_code != cfg_target;
  assign step_up = cfg_target > pll_code;
  assign pll_en  = cfg_enable;
  assign ref_clk = cfg_src_sel ? osc_xtal : osc_rc;
  assign sys_clk = ready ? pll_clk : ref_clk;
  assign busy    = ready && (differs || settle_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_code   <= '0;
      ready      <= 1'b0;
      settle_cnt <= '0;
    end else if (!cfg_enable) begin
      pll_code   <= cfg_target;
      ready      <= 1'b0;
      settle_cnt <= '0;
    end else if (!ready) begin
      pll_code   <= cfg_target;
      ready      <= pll_lock;
      settle_cnt <= '0;
    end else if (settle_cnt != '0) begin
      settle_cnt <= settle_cnt - 1'b1;
    end else if (differs) begin
      pll_code   <= step_up ? pll_code + 1'b1 : pll_code - 1'b1;
      settle_cnt <= CNT_W'(SETTLE);
    end
  end

  p_single_stage_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready)) |->
      (pll_code == $past(pll_code) ||
       {1'b0, pll_code} == {1'b0, $past(pll_code)} + 1'b1 ||
       {1'b0, $past(pll_code)} == {1'b0, pll_code} + 1'b1));

  p_hold_after_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready) && pll_code != $past(pll_code) && cfg_enable) |=> $stable(pll_code));

  p_ready_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cfg_enable) |=> ready);

  p_ready_needs_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(pll_lock) && $past(cfg_enable)));

  p_disable_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (!ready && !busy && pll_code == $past(cfg_target)));
endmodule

// File: tb/test_pll_step_seq.sv
module test_pll_step_seq;
  localparam int W = 3;
  localparam int S = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 1'b0, cfg_src_sel = 1'b0;
  logic [W-1:0] cfg_target = '0;
  logic osc_rc = 1'b0, osc_xtal = 1'b0, pll_clk = 1'b0, pll_lock = 1'b0;
  logic pll_en, ref_clk, sys_clk, ready, busy;
  logic [W-1:0] pll_code;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  pll_step_seq #(.CODE_W(W), .SETTLE(S)) i_pll_step_seq (
    .clk, .rst_n, .cfg_enable, .cfg_src_sel, .cfg_target, .osc_rc, .osc_xtal,
    .pll_clk, .pll_lock, .pll_en, .pll_code, .ref_clk, .sys_clk, .ready, .busy);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bring_up(input int code);
    @(negedge clk);
    cfg_enable = 1'b0;
    cfg_target = W'(code);
    pll_lock = 1'b1;
    @(negedge clk);
    cfg_enable = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready", int'(ready), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 code", int'(pll_code), 0);
    rst_n = 1'b1;

    // R7 R8: reference selection and bypass
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      {cfg_src_sel, osc_rc, osc_xtal, pll_clk} = 4'(v);
      #1;
      chk("R7 ref_clk", int'(ref_clk), cfg_src_sel ? int'(osc_xtal) : int'(osc_rc));
      chk("R8 bypass", int'(sys_clk), int'(ref_clk));
    end

    // R2 R6: ready waits for lock, code tracks target meanwhile
    @(negedge clk);
    pll_lock = 1'b0;
    cfg_target = 3'd5;
    cfg_enable = 1'b1;
    #1;
    chk("R2 pll_en", int'(pll_en), 1);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R6 ready before lock", int'(ready), 0);
      chk("R2 code tracks", int'(pll_code), 5);
    end
    cfg_target = 3'd2;
    @(negedge clk);
    chk("R2 code jump while not ready", int'(pll_code), 2);
    pll_lock = 1'b1;
    @(negedge clk);
    chk("R6 ready after lock", int'(ready), 1);
    cfg_src_sel = 1'b0; osc_rc = 1'b0; pll_clk = 1'b1;
    #1;
    chk("R8 multiplier clock", int'(sys_clk), 1);

    // R5: lock drops during a walk, ready stays
    pll_lock = 1'b0;
    cfg_target = 3'd4;
    for (int k = 0; k < 2 * (S + 1) + 2; k++) begin
      @(negedge clk);
      chk("R5 ready sticky", int'(ready), 1);
    end
    chk("R5 walk done", int'(pll_code), 4);

    // R3 R4 R9: exhaustive start/end sweep
    for (int s = 0; s < 8; s++) begin
      for (int e = 0; e < 8; e++) begin
        int ad, dir, lim;
        bring_up(s);
        chk("R2 start code", int'(pll_code), s);
        ad = (e > s) ? e - s : s - e;
        dir = (e > s) ? 1 : -1;
        cfg_target = W'(e);
        #1;
        chk("R9 busy on write", int'(busy), (ad != 0) ? 1 : 0);
        lim = ad * (S + 1) + 2;
        for (int k = 1; k <= lim; k++) begin
          int n;
          @(negedge clk);
          n = (k - 1) / (S + 1) + 1;
          if (n > ad) n = ad;
          chk("R3 R4 code", int'(pll_code), s + dir * n);
          chk("R9 busy", int'(busy), (k < ad * (S + 1)) ? 1 : 0);
          chk("R5 ready", int'(ready), 1);
        end
      end
    end

    // R10: reverse during a running delay
    bring_up(0);
    cfg_target = 3'd7;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (k == 1) chk("R10 first step", int'(pll_code), 1);
      if (k == 3) cfg_target = 3'd0;
      if (k == 5) chk("R10 delay kept", int'(pll_code), 1);
      if (k == 6) chk("R10 step to new target", int'(pll_code), 0);
      if (k == 9) chk("R10 busy in last delay", int'(busy), 1);
      if (k == 10) chk("R10 busy clears", int'(busy), 0);
    end

    // R11: abort a walk
    bring_up(2);
    cfg_target = 3'd6;
    @(negedge clk);
    @(negedge clk);
    chk("R11 mid walk code", int'(pll_code), 3);
    cfg_enable = 1'b0;
    #1;
    chk("R11 pll_en low", int'(pll_en), 0);
    @(negedge clk);
    chk("R11 code to target", int'(pll_code), 6);
    chk("R11 ready clear", int'(ready), 0);
    chk("R11 busy clear", int'(busy), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule